// File: doc/BRIEF.md
# Shadow Register File for Miss-Tolerant Speculation

This block holds two copies of the architectural integer registers. The main copy receives ordinary retirement writes. The shadow copy is used only while the core speculates past a long-latency load miss. In that mode, instructions leave the head of the reorder window and write their results into the shadow copy. Instructions still waiting on the miss leave a poison mark instead of a value.

A pulse on the enter input copies the whole main file into the shadow file in a single edge and clears every poison mark. From the next cycle, reads and commits use the shadow file. A pulse on the exit input returns selection to the main file, which has not changed during speculation. A newly arriving instruction reads its sources through 2N read ports. A port that reports the wait bit tells the instruction that it depends on the outstanding miss, so it must not be scheduled and must mark its own destination as waiting. Commits from the same cycle reach the read ports through a bypass.

Top module: `ra_shadow_rf`

## Requirements
- R1: After reset the block is in normal mode (`ra_mode` = 0), and every read port returns data 0 with wait 0.
- R2: `ra_enter` in normal mode sets `ra_mode` to 1 at the next edge. At that edge the shadow file takes the main file contents, including the commits of that same cycle, and all wait bits clear. Reads in the entry cycle return those copied values.
- R3: While `ra_mode` = 1, commits change only the shadow file. After exit, reads return the main-file values from before entry, plus any commits made in the entry cycle.
- R4: In run-ahead mode, a commit with `cm_done` = 0 sets the destination wait bit and leaves its stored data unchanged. Reads of that register then return wait = 1.
- R5: In run-ahead mode, a commit with `cm_done` = 1 stores `cm_data` and clears the destination wait bit.
- R6: `ra_exit` in run-ahead mode clears `ra_mode` at the next edge. From then on, reads return main-file values with wait = 0.
- R7: When several commit ports target the same register in one cycle, the highest-index port decides both the stored data and the wait state.
- R8: A read port whose address matches a valid commit in the current cycle returns the value that commit will leave, with no cycle of delay.
- R9: In normal mode every valid commit writes its data to the main file, whatever `cm_done` is, and every read returns wait = 0.
- R10: `ra_enter` has no effect while `ra_mode` = 1, and `ra_exit` has no effect while `ra_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_enter | input | 1 | Request to enter run-ahead mode (copy main into shadow) |
| ra_exit | input | 1 | Request to leave run-ahead mode |
| cm_valid | input | NCOMMIT | Commit port valid flags; a higher index means a younger instruction |
| cm_dest | input | NCOMMIT x log2(NREG) | Commit destination register per port |
| cm_data | input | NCOMMIT x XLEN | Commit result value per port |
| cm_done | input | NCOMMIT | 1 = result computed, 0 = instruction waits on a miss |
| rd_addr | input | 2·NCOMMIT x log2(NREG) | Source register address per read port |
| rd_data | output | 2·NCOMMIT x XLEN | Source value per read port |
| rd_wait | output | 2·NCOMMIT | 1 = source depends on the outstanding miss |
| ra_mode | output | 1 | 1 while the shadow file is selected |

## Verification
Read results are combinational, so they are due in the same cycle as the address and any bypassed commit. Mode changes, the bulk copy and stored commits take effect at the next rising edge. The bench sets all inputs just after a falling edge and compares every read port and `ra_mode` with its behavioural model 1 ns later. It then advances the model at the rising edge with the same inputs. Every result is therefore compared in the cycle where it is due, including entry-cycle reads, same-register port collisions and requests to enter or exit that must be ignored.

// File: rtl/ra_rf_pkg.sv
package ra_rf_pkg;
  typedef enum logic {
    RF_SEL_MAIN   = 1'b0,
    RF_SEL_SHADOW = 1'b1
  } rf_sel_e;

  localparam int unsigned DEF_NREG    = 16;
  localparam int unsigned DEF_XLEN    = 32;
  localparam int unsigned DEF_NCOMMIT = 2;
endpackage

// File: rtl/ra_rf_mode_ctl.sv
module ra_rf_mode_ctl
  import ra_rf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go_ahead,
  input  logic    go_back,
  output rf_sel_e sel,
  output logic    take_copy,
  output logic    leave
);
  // A request is honoured only in the mode where it means something.
  assign take_copy = go_ahead && (sel == RF_SEL_MAIN);
  assign leave     = go_back  && (sel == RF_SEL_SHADOW);

  always_ff @(posedge clk) begin
    if (!rst_n)         sel <= RF_SEL_MAIN;
    else if (take_copy) sel <= RF_SEL_SHADOW;
    else if (leave)     sel <= RF_SEL_MAIN;
  end
endmodule

// File: rtl/ra_rf_bank.sv
module ra_rf_bank #(
  parameter  int NREG      = 16,
  parameter  int XLEN      = 32,
  parameter  int NWR       = 2,
  parameter  bit WITH_WAIT = 1'b1,
  localparam int AW        = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       copy_en,
  input  logic [NREG-1:0][XLEN-1:0]  copy_data,
  input  logic [NWR-1:0]             we,
  input  logic [NWR-1:0][AW-1:0]     waddr,
  input  logic [NWR-1:0][XLEN-1:0]   wdata,
  input  logic [NWR-1:0]             wwait,
  output logic [NREG-1:0][XLEN-1:0]  q_data,
  output logic [NREG-1:0]            q_wait
);
  // Ports are applied in ascending order, so the highest index wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_data <= '0;
    end else if (copy_en) begin
      q_data <= copy_data;
    end else begin
      for (int p = 0; p < NWR; p++)
        if (we[p] && !wwait[p]) q_data[waddr[p]] <= wdata[p];
    end
  end

  generate
    if (WITH_WAIT) begin : g_wait
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_wait <= '0;
        end else if (copy_en) begin
          q_wait <= '0;
        end else begin
          for (int p = 0; p < NWR; p++)
            if (we[p]) q_wait[waddr[p]] <= wwait[p];
        end
      end
    end else begin : g_nowait
      assign q_wait = '0;
    end
  endgenerate
endmodule

// File: rtl/ra_shadow_rf.sv
module ra_shadow_rf
  import ra_rf_pkg::*;
#(
  parameter  int NREG    = DEF_NREG,
  parameter  int XLEN    = DEF_XLEN,
  parameter  int NCOMMIT = DEF_NCOMMIT,
  localparam int AW      = $clog2(NREG),
  localparam int NRD     = 2 * NCOMMIT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ra_enter,
  input  logic                         ra_exit,
  input  logic [NCOMMIT-1:0]           cm_valid,
  input  logic [NCOMMIT-1:0][AW-1:0]   cm_dest,
  input  logic [NCOMMIT-1:0][XLEN-1:0] cm_data,
  input  logic [NCOMMIT-1:0]           cm_done,
  input  logic [NRD-1:0][AW-1:0]       rd_addr,
  output logic [NRD-1:0][XLEN-1:0]     rd_data,
  output logic [NRD-1:0]               rd_wait,
  output logic                         ra_mode
);
  rf_sel_e                    sel;
  logic                       take_copy;
  logic                       leave;
  logic                       in_shadow;
  logic [NCOMMIT-1:0]         main_we;
  logic [NCOMMIT-1:0]         shadow_we;
  logic [NCOMMIT-1:0]         poison;
  logic [NREG-1:0][XLEN-1:0]  main_q;
  logic [NREG-1:0]            main_wq;
  logic [NREG-1:0][XLEN-1:0]  shadow_q;
  logic [NREG-1:0]            shadow_wq;
  logic [NREG-1:0][XLEN-1:0]  copy_src;

  // Value a register holds after this cycle's commits.
  function automatic logic [XLEN-1:0] fold_data(input logic [AW-1:0] a,
                                                input logic [XLEN-1:0] base,
                                                input logic spec);
    logic [XLEN-1:0] d;
    d = base;
    for (int p = 0; p < NCOMMIT; p++)
      if (cm_valid[p] && cm_dest[p] == a && !(spec && !cm_done[p])) d = cm_data[p];
    return d;
  endfunction

  // Wait state after this cycle's commits; poison exists only in speculation.
  function automatic logic fold_wait(input logic [AW-1:0] a,
                                     input logic base,
                                     input logic spec);
    logic w;
    w = base;
    for (int p = 0; p < NCOMMIT; p++)
      if (cm_valid[p] && cm_dest[p] == a) w = spec && !cm_done[p];
    return w;
  endfunction

  ra_rf_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .go_ahead(ra_enter), .go_back(ra_exit),
    .sel(sel), .take_copy(take_copy), .leave(leave)
  );

  assign in_shadow = (sel == RF_SEL_SHADOW);
  assign ra_mode   = in_shadow;
  assign main_we   = cm_valid & {NCOMMIT{!in_shadow}};
  assign shadow_we = cm_valid & {NCOMMIT{in_shadow}};
  assign poison    = ~cm_done;

  // The copy source includes the commits retiring in the entry cycle.
  generate
    for (genvar r = 0; r < NREG; r++) begin : g_copy
      assign copy_src[r] = fold_data(AW'(r), main_q[r], 1'b0);
    end
  endgenerate

  ra_rf_bank #(.NREG(NREG), .XLEN(XLEN), .NWR(NCOMMIT), .WITH_WAIT(1'b0)) u_main (
    .clk(clk), .rst_n(rst_n), .copy_en(1'b0), .copy_data('0),
    .we(main_we), .waddr(cm_dest), .wdata(cm_data), .wwait('0),
    .q_data(main_q), .q_wait(main_wq)
  );

  ra_rf_bank #(.NREG(NREG), .XLEN(XLEN), .NWR(NCOMMIT), .WITH_WAIT(1'b1)) u_shadow (
    .clk(clk), .rst_n(rst_n), .copy_en(take_copy), .copy_data(copy_src),
    .we(shadow_we), .waddr(cm_dest), .wdata(cm_data), .wwait(poison),
    .q_data(shadow_q), .q_wait(shadow_wq)
  );

  generate
    for (genvar i = 0; i < NRD; i++) begin : g_rd
      logic [XLEN-1:0] base_d;
      logic            base_w;
      assign base_d     = in_shadow ? shadow_q[rd_addr[i]]  : main_q[rd_addr[i]];
      assign base_w     = in_shadow ? shadow_wq[rd_addr[i]] : main_wq[rd_addr[i]];
      assign rd_data[i] = fold_data(rd_addr[i], base_d, in_shadow);
      assign rd_wait[i] = fold_wait(rd_addr[i], base_w, in_shadow);
    end
  endgenerate
endmodule

// File: rtl/ra_shadow_rf_chk.sv
module ra_shadow_rf_chk #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int NRD  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ra_enter,
  input logic                      ra_exit,
  input logic                      ra_mode,
  input logic                      take_copy,
  input logic                      leave,
  input logic [NRD-1:0]            rd_wait,
  input logic [NREG-1:0][XLEN-1:0] main_q,
  input logic [NREG-1:0]           shadow_wq
);
  p_enter_sets_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_copy |=> ra_mode);

  p_copy_clears_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_copy |=> (shadow_wq == '0));

  p_main_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && $past(ra_mode)) |-> $stable(main_q));

  p_exit_clears_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> !ra_mode);

  p_no_wait_in_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ra_mode |-> (rd_wait == '0));

  p_enter_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && ra_enter && !ra_exit) |=> ra_mode);

  p_exit_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_mode && ra_exit && !ra_enter) |=> !ra_mode);
endmodule

bind ra_shadow_rf ra_shadow_rf_chk #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD)) chk_i (
  .clk(clk), .rst_n(rst_n), .ra_enter(ra_enter), .ra_exit(ra_exit),
  .ra_mode(ra_mode), .take_copy(take_copy), .leave(leave),
  .rd_wait(rd_wait), .main_q(main_q), .shadow_wq(shadow_wq)
);

// File: tb/ra_shadow_rf_tb_top.sv
`timescale 1ns/1ps
module ra_shadow_rf_tb_top;
  localparam int NREG = 16;
  localparam int XLEN = 32;
  localparam int NC   = 2;
  localparam int AW   = 4;
  localparam int NRD  = 2 * NC;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    ra_enter = 1'b0;
  logic                    ra_exit = 1'b0;
  logic [NC-1:0]           cm_valid = '0;
  logic [NC-1:0][AW-1:0]   cm_dest = '0;
  logic [NC-1:0][XLEN-1:0] cm_data = '0;
  logic [NC-1:0]           cm_done = '0;
  logic [NRD-1:0][AW-1:0]  rd_addr = '0;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  logic [NRD-1:0]          rd_wait;
  logic                    ra_mode;

  // Reference state
  logic [XLEN-1:0] m_main [NREG];
  logic [XLEN-1:0] m_sh   [NREG];
  bit              m_shw  [NREG];
  bit              m_mode;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ra_shadow_rf #(.NREG(NREG), .XLEN(XLEN), .NCOMMIT(NC)) dut_i (.*);

  task automatic model_reset();
    for (int r = 0; r < NREG; r++) begin m_main[r] = '0; m_sh[r] = '0; m_shw[r] = 0; end
    m_mode = 0;
  endtask

  task automatic clear_in();
    ra_enter = 0; ra_exit = 0; cm_valid = '0; cm_done = '0;
  endtask

  task automatic cm(input int p, input int dest, input logic [XLEN-1:0] data, input bit done);
    cm_valid[p] = 1'b1; cm_dest[p] = AW'(dest); cm_data[p] = data; cm_done[p] = done;
  endtask

  task automatic rd(input int a0, input int a1, input int a2, input int a3);
    rd_addr[0] = AW'(a0); rd_addr[1] = AW'(a1); rd_addr[2] = AW'(a2); rd_addr[3] = AW'(a3);
  endtask

  task automatic check_now(input string tag);
    #1;
    n_checks++;
    if (ra_mode !== m_mode) begin
      n_fails++;
      $display("FAIL %s mode: actual %0b expected %0b", tag, ra_mode, m_mode);
    end
    for (int i = 0; i < NRD; i++) begin
      int              a;
      logic [XLEN-1:0] ed;
      bit              ew;
      a  = int'(rd_addr[i]);
      ed = m_mode ? m_sh[a] : m_main[a];
      ew = m_mode ? m_shw[a] : 1'b0;
      for (int p = 0; p < NC; p++)
        if (cm_valid[p] && int'(cm_dest[p]) == a) begin
          if (m_mode && !cm_done[p]) ew = 1'b1;
          else begin ed = cm_data[p]; ew = 1'b0; end
        end
      n_checks++;
      if (rd_wait[i] !== ew || (!ew && rd_data[i] !== ed)) begin
        n_fails++;
        $display("FAIL %s port %0d reg %0d: actual wait %0b data %h expected wait %0b data %h",
                 tag, i, a, rd_wait[i], rd_data[i], ew, ed);
      end
    end
  endtask

  task automatic model_edge();
    if (!m_mode) begin
      for (int p = 0; p < NC; p++)
        if (cm_valid[p]) m_main[int'(cm_dest[p])] = cm_data[p];
      if (ra_enter) begin
        for (int r = 0; r < NREG; r++) begin m_sh[r] = m_main[r]; m_shw[r] = 0; end
        m_mode = 1;
      end
    end else begin
      for (int p = 0; p < NC; p++)
        if (cm_valid[p]) begin
          if (cm_done[p]) begin m_sh[int'(cm_dest[p])] = cm_data[p]; m_shw[int'(cm_dest[p])] = 0; end
          else m_shw[int'(cm_dest[p])] = 1;
        end
      if (ra_exit) m_mode = 0;
    end
  endtask

  task automatic cyc(input string tag);
    check_now(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    clear_in();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    rd(0, 5, 9, 15); cyc("R1 reset");

    // R9: normal commits, done flag irrelevant; R8 bypass on same cycle
    cm(0, 1, 32'h1111_0001, 1'b0); cm(1, 2, 32'h2222_0002, 1'b1);
    rd(1, 2, 3, 1); cyc("R9/R8 normal commit");
    rd(1, 2, 0, 3); cyc("R9 stored");

    // R7: two ports same register in normal mode
    cm(0, 4, 32'hAAAA_0000, 1'b1); cm(1, 4, 32'hBBBB_0000, 1'b1);
    rd(4, 4, 1, 2); cyc("R7 collision normal");
    rd(4, 1, 2, 0); cyc("R7 stored");

    // R10: exit ignored in normal mode
    ra_exit = 1; rd(4, 1, 2, 3); cyc("R10 exit ignored");

    // R2: entry with commits in same cycle; reads return copied values
    ra_enter = 1; cm(1, 3, 32'h3333_0003, 1'b1); rd(3, 1, 4, 2);
    cyc("R2 entry cycle");
    rd(3, 1, 4, 2); cyc("R2 after copy");

    // R4: undone commit poisons; R5: done commit writes
    cm(0, 1, 32'hDEAD_DEAD, 1'b0); cm(1, 2, 32'h5555_0005, 1'b1);
    rd(1, 2, 3, 4); cyc("R4/R5 commit bypass");
    rd(1, 2, 3, 4); cyc("R4 poison stored");
    cm(0, 1, 32'h6666_0006, 1'b1); rd(1, 1, 2, 0); cyc("R5 clears poison");
    rd(1, 2, 0, 5); cyc("R5 stored");

    // R7 in run-ahead: younger port decides wait state
    cm(0, 6, 32'h7777_0007, 1'b1); cm(1, 6, 32'h0, 1'b0);
    rd(6, 6, 1, 2); cyc("R7 younger poisons");
    cm(0, 6, 32'h0, 1'b0); cm(1, 6, 32'h8888_0008, 1'b1);
    rd(6, 5, 1, 2); cyc("R7 younger clears");
    rd(6, 5, 1, 2); cyc("R7 stored");

    // R10: enter ignored while active (no recopy: poison kept)
    cm(0, 7, 32'h0, 1'b0); rd(7, 6, 1, 2); cyc("R4 poison reg7");
    ra_enter = 1; rd(7, 6, 1, 2); cyc("R10 enter ignored");
    rd(7, 6, 1, 2); cyc("R10 poison kept");

    // R6/R3: exit, main file untouched by speculation
    cm(0, 3, 32'h9999_0009, 1'b1); ra_exit = 1; rd(3, 1, 2, 6); cyc("R3 last shadow commit");
    rd(3, 1, 2, 6); cyc("R6/R3 main restored");
    rd(7, 4, 0, 5); cyc("R6 no wait after exit");

    // Mixed traffic: R2 R3 R4 R5 R7 R8 R9 R10
    for (int k = 0; k < 3000; k++) begin
      cm_valid = NC'($urandom);
      cm_done  = NC'($urandom);
      for (int p = 0; p < NC; p++) begin
        cm_dest[p] = AW'($urandom_range(0, 7));
        cm_data[p] = $urandom;
      end
      for (int i = 0; i < NRD; i++) rd_addr[i] = AW'($urandom_range(0, 7));
      ra_enter = ($urandom_range(0, 15) == 0);
      ra_exit  = ($urandom_range(0, 15) == 0);
      cyc("R2/R3/R4/R5/R7/R8/R9/R10 mixed");
    end

    report();
  end
endmodule